// File: doc/BRIEF.md
# EEPROM Page Load and Program Controller

This block implements the write side of a byte-wide parallel EEPROM. An external master drives active-low chip-select, write-enable and output-enable strobes together with an address and a data byte. The strobes are asynchronous in style, and the block samples them on its system clock. Short low pulses on the two write strobes are filtered out. Each accepted write cycle drops its byte into a page buffer, at the slot given by the low address bits. The upper address bits of the first byte in a load fix the page that the load goes to.

Every accepted write start restarts a load window. When the window runs out with no write in progress, the block enters a program phase of fixed length. During that phase it walks the page slots in ascending order and issues one array write for each slot that was loaded. Slots that were not loaded get no write, so the array keeps their old contents.

A power-good input holds off all writes while it is low, and for a set delay after it rises. All durations are parameters counted in clock cycles.

Top module: `eeprom_page_ctrl`

## Requirements
- R1: After reset, `busy` is 0 and `arr_we` is 0.
- R2: A write is taken only while `sel_n`=0, `wen_n`=0 and `oen_n`=1. The following store nothing and leave `busy` low: a cycle held with `oen_n`=0, a `wen_n` pulse while `sel_n`=1, and a cycle in which `oen_n` drops before the strobes rise.
- R3: The byte slot and page come from `addr` once both write strobes are low, which is the later of the two falling edges. The data comes from `din` at the earlier of the two rising edges. A change to `din` after that edge has no effect.
- R4: A low pulse on a write strobe that lasts fewer than GLITCH_CYC clock samples starts no write. `busy` stays 0 and no array write follows.
- R5: While `supply_ok` is 0, and for PWRUP_CYC cycles after it rises, write cycles are ignored. After that delay, writes are accepted.
- R6: `busy` rises after the first accepted byte of a load. It stays high through the load and program phases, and falls when the program phase ends.
- R7: Each accepted write start restarts the LOAD_CYC load window. Bytes whose starts are closer together than the window all go into one program phase.
- R8: The program phase lasts PROG_CYC cycles whatever the number of bytes loaded. Each loaded byte is written once to the array at {page, slot}, with `addr[OFS_W-1:0]` as the slot.
- R9: Slots that were not loaded get no array write. A slot loaded twice is written once, with the last value loaded. Array writes within a phase go in ascending slot order.
- R10: The page of a load is set by the upper address bits `addr[ADDR_W-1:OFS_W]` of its first byte. Later bytes of the same load use only their slot bits.
- R11: Write cycles during the program phase are ignored. They are not buffered and they start no later program phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Power-good indication; writes are locked out while low |
| sel_n | input | 1 | Chip select, active low |
| wen_n | input | 1 | Write enable, active low |
| oen_n | input | 1 | Output enable, active low; a low level inhibits writes |
| addr | input | ADDR_W | Byte address; the low OFS_W bits select the page slot |
| din | input | DATA_W | Write data byte |
| busy | output | 1 | High from the first accepted byte to the end of programming |
| arr_we | output | 1 | Array write strobe, one cycle per programmed byte |
| arr_addr | output | ADDR_W | Array write address {page, slot} |
| arr_data | output | DATA_W | Array write data |

## Verification
The bench spaces byte writes closer together than the load window, over a total span much longer than the window. A design that timed the window from the first byte would split that burst into several program phases. It measures the time from the final strobe release to the fall of `busy` for a one-byte load and for a five-byte load. A program time that grew with the byte count would show up as a difference between the two.

The order of the strobe edges is skewed so that the address changes between the two falling edges and the data changes between the two rising edges. Sampling at the wrong edge would store the wrong byte at the wrong location. Further cases cover:
- a rewritten slot;
- a second byte from a different page;
- a sub-filter pulse;
- an output-enable abort;
- a write made during the power-up delay;
- a write made during programming.

In each case the bench confirms that no stray array write or extra phase occurs.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
    typedef enum logic [1:0] {
        PG_IDLE = 2'd0,
        PG_LOAD = 2'd1,
        PG_PROG = 2'd2
    } pg_state_e;
endpackage

// File: rtl/pgw_strobe_filt.sv
// Low-going glitch filter: the output falls only after GLITCH_CYC
// consecutive low samples; it rises on the first high sample.
module pgw_strobe_filt #(
    parameter int GLITCH_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_n,
    output logic filt_n
);
    localparam int CW = (GLITCH_CYC > 1) ? $clog2(GLITCH_CYC) : 1;

    typedef struct packed {
        logic          filt;
        logic [CW-1:0] cnt;
    } flt_t;

    flt_t q, d;

    always_comb begin
        d = q;
        if (raw_n) begin
            d.filt = 1'b1;
            d.cnt  = '0;
        end else if (q.filt) begin
            if (q.cnt == CW'(GLITCH_CYC - 1)) begin
                d.filt = 1'b0;
                d.cnt  = '0;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.filt <= 1'b1;
            q.cnt  <= '0;
        end else begin
            q <= d;
        end
    end

    assign filt_n = q.filt;
endmodule

// File: rtl/pgw_pwr_guard.sv
// Holds writes off while supply is low and for PWRUP_CYC cycles after it rises.
module pgw_pwr_guard #(
    parameter int PWRUP_CYC = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    output logic locked
);
    localparam int CW = (PWRUP_CYC > 1) ? $clog2(PWRUP_CYC) : 1;

    typedef struct packed {
        logic          lock;
        logic [CW-1:0] cnt;
    } grd_t;

    grd_t q, d;

    always_comb begin
        d = q;
        if (!supply_ok) begin
            d.lock = 1'b1;
            d.cnt  = '0;
        end else if (q.lock) begin
            if (q.cnt == CW'(PWRUP_CYC - 1)) begin
                d.lock = 1'b0;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.lock <= 1'b1;
            q.cnt  <= '0;
        end else begin
            q <= d;
        end
    end

    assign locked = q.lock;
endmodule

// File: rtl/pgw_cycle_timer.sv
// Up-counter that restarts from zero on start and saturates at LIMIT-1.
module pgw_cycle_timer #(
    parameter int LIMIT = 4,
    parameter int CW    = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          en,
    output logic [CW-1:0] count
);
    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t q, d;

    always_comb begin
        d = q;
        if (start) begin
            d.cnt = '0;
        end else if (en && (q.cnt != CW'(LIMIT - 1))) begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.cnt <= '0;
        end else begin
            q <= d;
        end
    end

    assign count = q.cnt;
endmodule

// File: rtl/eeprom_page_ctrl.sv
module eeprom_page_ctrl
    import pgw_pkg::*;
#(
    parameter int ADDR_W     = 17,
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 128,
    parameter int LOAD_CYC   = 15000,
    parameter int PROG_CYC   = 1000000,
    parameter int PWRUP_CYC  = 500000,
    parameter int GLITCH_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              supply_ok,
    input  logic              sel_n,
    input  logic              wen_n,
    input  logic              oen_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic              busy,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_data
);
    localparam int OFS_W = $clog2(PAGE_BYTES);
    localparam int TAG_W = ADDR_W - OFS_W;
    localparam int LCW   = (LOAD_CYC > 1) ? $clog2(LOAD_CYC) : 1;
    localparam int PCW   = (PROG_CYC > 1) ? $clog2(PROG_CYC) : 1;

    typedef struct packed {
        pg_state_e                         state;
        logic                              s_sel_n;
        logic                              s_wen_n;
        logic                              s_oen_n;
        logic [ADDR_W-1:0]                 s_addr;
        logic [DATA_W-1:0]                 s_din;
        logic                              prev_act;
        logic                              acc;
        logic [OFS_W-1:0]                  ofs;
        logic [TAG_W-1:0]                  tag;
        logic [TAG_W-1:0]                  page;
        logic [PAGE_BYTES-1:0]             vld;
        logic [PAGE_BYTES-1:0][DATA_W-1:0] pbuf;
    } ctl_t;

    ctl_t q, d;

    logic [1:0]       strb_s;
    logic [1:0]       f_n;      // [0] chip select, [1] write enable
    logic             locked;
    logic             load_go, prog_go;
    logic [LCW-1:0]   load_cnt;
    logic [PCW-1:0]   prog_cnt;
    logic             load_done, prog_done;
    logic             act, start;
    logic [OFS_W-1:0] slot;
    logic             slot_live;

    assign strb_s = {q.s_wen_n, q.s_sel_n};

    genvar gi;
    generate
        for (gi = 0; gi < 2; gi++) begin : g_filt
            pgw_strobe_filt #(.GLITCH_CYC(GLITCH_CYC)) u_filt (
                .clk    (clk),
                .rst_n  (rst_n),
                .raw_n  (strb_s[gi]),
                .filt_n (f_n[gi])
            );
        end
    endgenerate

    pgw_pwr_guard #(.PWRUP_CYC(PWRUP_CYC)) u_guard (
        .clk       (clk),
        .rst_n     (rst_n),
        .supply_ok (supply_ok),
        .locked    (locked)
    );

    pgw_cycle_timer #(.LIMIT(LOAD_CYC), .CW(LCW)) u_load_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (load_go),
        .en    (1'b1),
        .count (load_cnt)
    );

    pgw_cycle_timer #(.LIMIT(PROG_CYC), .CW(PCW)) u_prog_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (prog_go),
        .en    (q.state == PG_PROG),
        .count (prog_cnt)
    );

    assign load_done = (load_cnt == LCW'(LOAD_CYC - 1));
    assign prog_done = (prog_cnt == PCW'(PROG_CYC - 1));

    always_comb begin
        d       = q;
        load_go = 1'b0;
        prog_go = 1'b0;

        d.s_sel_n = sel_n;
        d.s_wen_n = wen_n;
        d.s_oen_n = oen_n;
        d.s_addr  = addr;
        d.s_din   = din;

        act        = !f_n[0] && !f_n[1] && q.s_oen_n;
        start      = act && !q.prev_act;
        d.prev_act = act;

        if (q.acc) begin
            if (!q.s_oen_n) begin
                d.acc = 1'b0;               // output enable dropped: abandon
            end else if (f_n[0] || f_n[1]) begin
                d.acc = 1'b0;               // earlier rising strobe latches data
                if (!locked) begin
                    d.pbuf[q.ofs] = q.s_din;
                    d.vld[q.ofs]  = 1'b1;
                    if (q.state == PG_IDLE) begin
                        d.state = PG_LOAD;
                        d.page  = q.tag;
                    end
                end
            end
        end else if (start && !locked && (q.state != PG_PROG)) begin
            d.acc   = 1'b1;                 // later falling strobe latches address
            d.ofs   = q.s_addr[OFS_W-1:0];
            d.tag   = q.s_addr[ADDR_W-1:OFS_W];
            load_go = 1'b1;
        end

        case (q.state)
            PG_LOAD: begin
                if (load_done && !q.acc && !load_go) begin
                    d.state = PG_PROG;
                    prog_go = 1'b1;
                end
            end
            PG_PROG: begin
                if (prog_done) begin
                    d.state = PG_IDLE;
                    d.vld   = '0;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q         <= '0;
            q.state   <= PG_IDLE;
            q.s_sel_n <= 1'b1;
            q.s_wen_n <= 1'b1;
            q.s_oen_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        slot      = prog_cnt[OFS_W-1:0];
        slot_live = (32'(prog_cnt) < PAGE_BYTES);
        busy      = (q.state != PG_IDLE);
        arr_we    = (q.state == PG_PROG) && slot_live && q.vld[slot];
        arr_addr  = {q.page, slot};
        arr_data  = q.pbuf[slot];
    end
endmodule

// File: rtl/pgw_checker.sv
module pgw_checker #(
    parameter int ADDR_W = 17,
    parameter int OFS_W  = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              supply_ok,
    input logic              busy,
    input logic              arr_we,
    input logic [ADDR_W-1:0] arr_addr
);
    AST_WE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> busy); // R8

    AST_PAGE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_we && $past(arr_we)) |->
            (arr_addr[ADDR_W-1:OFS_W] == $past(arr_addr[ADDR_W-1:OFS_W]))); // R10

    AST_SLOT_ASCENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_we && $past(arr_we)) |->
            (arr_addr[OFS_W-1:0] > $past(arr_addr[OFS_W-1:0]))); // R9

    AST_LOCK_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(supply_ok)) |=> !busy); // R5

    AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |=> !busy); // R11
endmodule

bind eeprom_page_ctrl pgw_checker #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_pgw_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .supply_ok (supply_ok),
    .busy      (busy),
    .arr_we    (arr_we),
    .arr_addr  (arr_addr)
);

// File: tb/eeprom_page_ctrl_bench.sv
module eeprom_page_ctrl_bench;
    localparam int AW = 8;
    localparam int DW = 8;
    localparam int PB = 8;
    localparam int LC = 40;
    localparam int PC = 30;
    localparam int PU = 20;
    localparam int GC = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          supply_ok = 1'b0;
    logic          sel_n = 1'b1;
    logic          wen_n = 1'b1;
    logic          oen_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic          busy;
    logic          arr_we;
    logic [AW-1:0] arr_addr;
    logic [DW-1:0] arr_data;

    eeprom_page_ctrl #(
        .ADDR_W(AW), .DATA_W(DW), .PAGE_BYTES(PB), .LOAD_CYC(LC),
        .PROG_CYC(PC), .PWRUP_CYC(PU), .GLITCH_CYC(GC)
    ) u_eeprom_page_ctrl (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .sel_n(sel_n),
        .wen_n(wen_n), .oen_n(oen_n), .addr(addr), .din(din), .busy(busy),
        .arr_we(arr_we), .arr_addr(arr_addr), .arr_data(arr_data)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int wr_cnt = 0;
    int phase_cnt = 0;
    logic busy_prev = 1'b0;
    logic [DW-1:0] seen [256] = '{default: 8'h00};

    always @(posedge clk) begin
        if (arr_we) begin
            seen[arr_addr] <= arr_data;
            wr_cnt <= wr_cnt + 1;
        end
        busy_prev <= busy;
        if (busy_prev && !busy) phase_cnt <= phase_cnt + 1;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr_byte(input logic [AW-1:0] a, input logic [DW-1:0] v);
        @(negedge clk);
        addr = a; din = v; sel_n = 1'b0; wen_n = 1'b0;
        repeat (6) @(negedge clk);
        sel_n = 1'b1; wen_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy && n < 2000) begin
            @(negedge clk);
            n++;
        end
        repeat (2) @(negedge clk);
    endtask

    int dur_one = 0;

    task automatic t_reset();
        @(negedge clk);
        chk("R1 busy after reset", int'(busy), 0);
        chk("R1 arr_we after reset", int'(arr_we), 0);
    endtask

    task automatic t_lockout();
        int n;
        wr_byte(8'h40, 8'h11);
        repeat (60) @(negedge clk);
        chk("R5 busy with supply low", int'(busy), 0);
        chk("R5 no array write with supply low", wr_cnt, 0);
        @(negedge clk) supply_ok = 1'b1;
        wr_byte(8'h41, 8'h12);
        repeat (40) @(negedge clk);
        chk("R5 busy during power-up delay", int'(busy), 0);
        chk("R5 no array write during delay", wr_cnt, 0);
        wr_byte(8'h42, 8'h13);
        chk("R5 R6 busy after unlock write", int'(busy), 1);
        wait_idle(n);
        chk("R5 byte stored after unlock", int'(seen[8'h42]), 8'h13);
        chk("R5 locked byte not stored", int'(seen[8'h41]), 0);
    endtask

    task automatic t_single();
        int w0, p0;
        w0 = wr_cnt; p0 = phase_cnt;
        wr_byte(8'h25, 8'hA5);
        chk("R6 busy after first byte", int'(busy), 1);
        wait_idle(dur_one);
        chk("R6 busy low after program", int'(busy), 0);
        chk("R8 single byte stored", int'(seen[8'h25]), 8'hA5);
        chk("R8 one array write", wr_cnt - w0, 1);
        chk("R6 one phase", phase_cnt - p0, 1);
    endtask

    task automatic t_page();
        int w0, p0, dur;
        w0 = wr_cnt; p0 = phase_cnt;
        for (int i = 0; i < 5; i++) wr_byte(AW'(8'h18 + i), DW'(8'hC0 + i));
        wait_idle(dur);
        chk("R8 program time independent of byte count", dur, dur_one);
        chk("R7 five bytes one phase", phase_cnt - p0, 1);
        chk("R8 five array writes", wr_cnt - w0, 5);
        for (int i = 0; i < 5; i++)
            chk("R8 page byte value", int'(seen[8'h18 + i]), 8'hC0 + i);
        chk("R9 unloaded slot untouched", int'(seen[8'h1D]), 0);
    endtask

    task automatic t_retrigger();
        int w0, p0, n;
        w0 = wr_cnt; p0 = phase_cnt;
        for (int i = 0; i < 4; i++) begin
            wr_byte(AW'(8'h60 + i), DW'(8'h70 + i));
            if (i < 3) begin
                repeat (25) @(negedge clk);
                chk("R7 busy held between spaced bytes", int'(busy), 1);
                chk("R7 no array write before window ends", wr_cnt - w0, 0);
            end
        end
        wait_idle(n);
        chk("R7 spaced bytes one phase", phase_cnt - p0, 1);
        chk("R7 spaced bytes all written", wr_cnt - w0, 4);
        chk("R7 last spaced byte", int'(seen[8'h63]), 8'h73);
    endtask

    task automatic t_glitch();
        int w0;
        w0 = wr_cnt;
        @(negedge clk);
        addr = 8'h80; din = 8'h5A; sel_n = 1'b0; wen_n = 1'b0;
        repeat (GC - 1) @(negedge clk);
        sel_n = 1'b1; wen_n = 1'b1;
        repeat (5) @(negedge clk);
        sel_n = 1'b0;
        repeat (6) @(negedge clk);
        wen_n = 1'b0;
        repeat (GC - 1) @(negedge clk);
        wen_n = 1'b1;
        repeat (4) @(negedge clk);
        sel_n = 1'b1;
        repeat (60) @(negedge clk);
        chk("R4 busy after short pulses", int'(busy), 0);
        chk("R4 no array write after short pulses", wr_cnt - w0, 0);
    endtask

    task automatic t_oen();
        int w0;
        w0 = wr_cnt;
        @(negedge clk) oen_n = 1'b0;
        wr_byte(8'h90, 8'h33);
        @(negedge clk) oen_n = 1'b1;
        repeat (50) @(negedge clk);
        chk("R2 output enable low blocks write", int'(busy), 0);
        @(negedge clk);
        addr = 8'h91; din = 8'h34; wen_n = 1'b0;
        repeat (6) @(negedge clk);
        wen_n = 1'b1;
        repeat (50) @(negedge clk);
        chk("R2 write enable alone blocked", int'(busy), 0);
        @(negedge clk);
        addr = 8'h92; din = 8'h35; sel_n = 1'b0; wen_n = 1'b0;
        repeat (7) @(negedge clk);
        oen_n = 1'b0;
        repeat (3) @(negedge clk);
        sel_n = 1'b1; wen_n = 1'b1;
        repeat (3) @(negedge clk);
        oen_n = 1'b1;
        repeat (50) @(negedge clk);
        chk("R2 aborted cycle leaves busy low", int'(busy), 0);
        chk("R2 no array write from blocked cycles", wr_cnt - w0, 0);
    endtask

    task automatic t_latch();
        int n;
        @(negedge clk);
        addr = 8'hA1; din = 8'h00; wen_n = 1'b0;
        repeat (6) @(negedge clk);
        addr = 8'hA6;
        repeat (2) @(negedge clk);
        sel_n = 1'b0; din = 8'hD1;
        repeat (8) @(negedge clk);
        sel_n = 1'b1;
        repeat (3) @(negedge clk);
        din = 8'hD2; addr = 8'hA1;
        repeat (3) @(negedge clk);
        wen_n = 1'b1;
        repeat (3) @(negedge clk);
        wait_idle(n);
        chk("R3 data from earlier rising edge", int'(seen[8'hA6]), 8'hD1);
        chk("R3 address from later falling edge", int'(seen[8'hA1]), 0);
    endtask

    task automatic t_page_tag();
        int n;
        wr_byte(8'h29, 8'h51);
        wr_byte(8'h32, 8'h52);
        wait_idle(n);
        chk("R10 first byte in first page", int'(seen[8'h29]), 8'h51);
        chk("R10 second byte follows first page", int'(seen[8'h2A]), 8'h52);
        chk("R10 other page untouched", int'(seen[8'h32]), 0);
    endtask

    task automatic t_overwrite();
        int w0, n;
        for (int i = 0; i < PB; i++) wr_byte(AW'(8'h10 + i), DW'(8'hE0 + i));
        wait_idle(n);
        w0 = wr_cnt;
        wr_byte(8'h13, 8'h11);
        wr_byte(8'h13, 8'h22);
        wait_idle(n);
        chk("R9 repeated slot keeps last value", int'(seen[8'h13]), 8'h22);
        chk("R9 repeated slot written once", wr_cnt - w0, 1);
        chk("R9 neighbour slot keeps old value", int'(seen[8'h12]), 8'hE2);
        chk("R9 top slot keeps old value", int'(seen[8'h17]), 8'hE7);
    endtask

    task automatic t_prog_ignore();
        int w0, p0, n;
        w0 = wr_cnt; p0 = phase_cnt;
        wr_byte(8'hB0, 8'h61);
        repeat (38) @(negedge clk);
        chk("R11 program phase running", int'(busy), 1);
        wr_byte(8'hB3, 8'h62);
        wait_idle(n);
        repeat (60) @(negedge clk);
        chk("R11 busy stays low after phase", int'(busy), 0);
        chk("R11 single phase", phase_cnt - p0, 1);
        chk("R11 write during program dropped", int'(seen[8'hB3]), 0);
        chk("R11 only first byte written", wr_cnt - w0, 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_lockout();
        t_single();
        t_page();
        t_retrigger();
        t_glitch();
        t_oen();
        t_latch();
        t_page_tag();
        t_overwrite();
        t_prog_ignore();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog all requirements actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule